// File: doc/BRIEF.md
# Byte Alignment Address and Data Unit

This unit helps software-visible datapaths deal with 64-bit words that straddle an 8-byte boundary. It has two operations, picked by a one-bit opcode on a start strobe. The address operation adds two 64-bit operands and returns the sum rounded down to an 8-byte boundary. It also stores the sum's byte-within-word position in a small internal lane-offset register.

The data operation treats its two 64-bit operands as a single 16-byte stream, first operand leading. It returns the 8 consecutive bytes that begin at the stored lane offset. The usual sequence is one address operation to establish the offset, followed by any number of data operations that reuse it. The coupling between the two operations lies entirely in that persistent offset. Every result is registered and appears together with a one-cycle valid pulse on the clock edge after the start.

Top module: `byte_align_unit`

## Requirements
- R1: After synchronous reset, `valid` is 0, `result` is 0 and the stored lane offset is 0, so a data operation issued first returns `opnd_a` unchanged.
- R2: With `start`=1 and `op`=0 (address operation), `result` on the next edge equals (`opnd_a` + `opnd_b`) with bits [2:0] forced to 0.
- R3: The address sum is taken modulo 2^64; a carry out of bit 63 is dropped.
- R4: An address operation writes bits [2:0] of the sum into the lane-offset register; nothing else writes it.
- R5: With `start`=1, `op`=1 (data operation) and stored offset k in 1..7, `result` equals (`opnd_a` << 8k) | (`opnd_b` >> (64-8k)), i.e. bytes k..k+7 of the 16-byte stream {`opnd_a`,`opnd_b`}, byte 0 being `opnd_a`[63:56].
- R6: With stored offset 0, a data operation returns `opnd_a` exactly, with no bits from `opnd_b`.
- R7: A data operation leaves the lane-offset register unchanged.
- R8: A data operation issued in the cycle directly after an address operation uses the offset that the address operation just wrote.
- R9: `valid` is 1 exactly in the cycle after each cycle with `start`=1 and is 0 otherwise; while `start` is 0, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue an operation this cycle |
| op | input | 1 | 0 = address operation, 1 = data operation |
| opnd_a | input | 64 | Address base / leading data word |
| opnd_b | input | 64 | Address displacement / trailing data word |
| valid | output | 1 | Result-ready pulse, one cycle after start |
| result | output | 64 | Registered result of the last operation |

## Verification
The assertions take for granted that `op` and both operands are at known levels whenever `start` is high, and that reset is asserted across at least one clock edge before the first operation. Their `$past` terms reach back only one cycle. The stimulus changes inputs only on the falling clock edge and drives known values on every input from time zero, so those assumptions always hold. Each address operation in the random phase sets a known offset, and the following data operations are compared against a byte-indexed model of the 16-byte stream.

// File: rtl/bal_pkg.sv
package bal_pkg;
  typedef enum logic {
    OP_ADDR = 1'b0,
    OP_DATA = 1'b1
  } bal_op_e;
endpackage

// File: rtl/bal_addr_unit.sv
module bal_addr_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]                      base,
  input  logic [DATA_W-1:0]                      displ,
  output logic [DATA_W-1:0]                      aligned,
  output logic [$clog2(DATA_W/LANE_W)-1:0]       lane_ofs
);
  localparam int NLANES = DATA_W / LANE_W;
  localparam int OFS_W  = $clog2(NLANES);

  logic [DATA_W-1:0] sum;

  // Modulo 2^DATA_W: carry out of the top bit falls off the same-width result.
  assign sum      = base + displ;
  assign aligned  = {sum[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
  assign lane_ofs = sum[OFS_W-1:0];
endmodule

// File: rtl/bal_funnel.sv
module bal_funnel #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]                      hi_word,
  input  logic [DATA_W-1:0]                      lo_word,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]       sel,
  output logic [DATA_W-1:0]                      merged
);
  localparam int NLANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] cand [NLANES];
  logic              unused_lo_lane;

  // Lowest lane of the trailing word can never reach the output.
  assign unused_lo_lane = ^lo_word[LANE_W-1:0];

  genvar g;
  generate
    for (g = 0; g < NLANES; g++) begin : g_cand
      if (g == 0) begin : g_pass
        assign cand[g] = hi_word;
      end else begin : g_join
        assign cand[g] = {hi_word[DATA_W-1-g*LANE_W:0],
                          lo_word[DATA_W-1 -: g*LANE_W]};
      end
    end
  endgenerate

  assign merged = cand[sel];
endmodule

// File: rtl/bal_align_reg.sv
module bal_align_reg #(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_val,
  output logic [OFS_W-1:0] ofs_q
);
  always_ff @(posedge clk) begin
    if (rst)        ofs_q <= '0;
    else if (wr_en) ofs_q <= wr_val;
  end

  // R4: a write lands on the next edge
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ofs_q == $past(wr_val));

  // R7: without a write the offset stays put
  p_hold_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ofs_q));
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              valid,
  output logic [DATA_W-1:0] result
);
  import bal_pkg::*;

  localparam int NLANES = DATA_W / LANE_W;
  localparam int OFS_W  = $clog2(NLANES);

  bal_op_e           op_e;
  logic [DATA_W-1:0] addr_res;
  logic [OFS_W-1:0]  new_ofs;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_res;
  logic              ofs_wr;

  assign op_e   = bal_op_e'(op);
  assign ofs_wr = start && (op_e == OP_ADDR);

  bal_addr_unit #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_addr (
    .base     (opnd_a),
    .displ    (opnd_b),
    .aligned  (addr_res),
    .lane_ofs (new_ofs)
  );

  bal_align_reg #(.OFS_W(OFS_W)) u_ofs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ofs_wr),
    .wr_val (new_ofs),
    .ofs_q  (ofs_q)
  );

  bal_funnel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_fun (
    .hi_word (opnd_a),
    .lo_word (opnd_b),
    .sel     (ofs_q),
    .merged  (data_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      result <= '0;
    end else begin
      valid <= start;
      if (start) result <= (op_e == OP_ADDR) ? addr_res : data_res;
    end
  end

  // R9: valid pulse follows start by one cycle
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(result));

  // R2: address results sit on an 8-byte boundary
  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !op) |=> result[OFS_W-1:0] == '0);

  // R6: zero offset passes the leading word through
  p_zero_ofs_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (start && op && ofs_q == '0) |=> result == $past(opnd_a));
endmodule

// File: tb/sim_byte_align_unit.sv
module sim_byte_align_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        valid;
  logic [63:0] result;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [2:0]  model_k = 3'd0;
  logic [63:0] last_res = '0;
  bit          done = 0;

  always #4 clk = ~clk;  // 125 MHz

  byte_align_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .valid(valid), .result(result)
  );

  // Byte-stream model: byte 0 is the top byte of the leading word.
  function automatic logic [63:0] ref_data(logic [63:0] a, logic [63:0] b, logic [2:0] k);
    logic [7:0]  stream [16];
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      stream[i]     = a[63-8*i -: 8];
      stream[i + 8] = b[63-8*i -: 8];
    end
    for (int i = 0; i < 8; i++) r[63-8*i -: 8] = stream[i + int'(k)];
    return r;
  endfunction

  function automatic logic [63:0] ref_addr(logic [63:0] a, logic [63:0] b);
    logic [64:0] full = {1'b0, a} + {1'b0, b};
    return {full[63:3], 3'b000};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Issues one operation at a falling edge; start stays high so calls chain back to back.
  task automatic do_op(logic o, logic [63:0] a, logic [63:0] b, string req);
    logic [63:0] exp;
    @(negedge clk);
    start = 1'b1; op = o; opnd_a = a; opnd_b = b;
    if (o == 1'b0) begin
      exp = ref_addr(a, b);
      model_k = 3'((a[2:0] + b[2:0]) & 3'h7);
    end else begin
      exp = ref_data(a, b, model_k);
    end
    @(negedge clk);
    check({req, " valid"}, {63'b0, valid}, 64'd1);
    check(req, result, exp);
    last_res = exp;
  endtask

  task automatic idle(int cycles);
    @(negedge clk);
    start = 1'b0; opnd_a = {$urandom, $urandom}; opnd_b = {$urandom, $urandom}; op = 1'($urandom);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R9 idle valid", {63'b0, valid}, 64'd0);
      check("R9 result hold", result, last_res);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'b0, valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst = 1'b0;
    // R1 / R6: first data op sees offset 0
    do_op(1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R1 R6 data after reset");
    idle(2);

    // R3: carry out of bit 63 dropped, offset 2
    do_op(1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, "R3 wrap sum");
    do_op(1'b1, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, "R8 R5 k2 back-to-back");
    // R7: second data op keeps the same offset
    do_op(1'b1, 64'hA0A1_A2A3_A4A5_A6A7, 64'hB0B1_B2B3_B4B5_B6B7, "R7 offset unchanged");
    idle(1);

    // R5 / R6 / R8: every offset, each set by an address op directly before
    for (int k = 0; k < 8; k++) begin
      ra = {$urandom, $urandom};
      ra[2:0] = 3'(k);
      do_op(1'b0, ra, 64'd0, "R2 R4 set offset");
      do_op(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, k == 0 ? "R6 k0 data" : "R5 R8 data");
      do_op(1'b1, 64'h0102_0304_0506_0708, 64'h090A_0B0C_0D0E_0F10, "R5 R7 pattern");
    end
    idle(3);

    // R2 R4 R5 R9: random mix
    for (int n = 0; n < 300; n++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) do_op(1'b0, ra, rb, "R2 R4 random addr");
      else                           do_op(1'b1, ra, rb, "R5 R7 random data");
      if ($urandom_range(0, 4) == 0) idle(1 + $urandom_range(0, 2));
    end
    idle(1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule